// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block is a host-side controller that clears one region of a serial flash device to all ones. The host presents a 24-bit byte address and a size select, which picks either a 4 KB sector or a 32 KB block, and pulses a start strobe. The sequencer then runs three chip-select frames on the serial bus. The first frame is a write-enable instruction. The second is the erase opcode followed by the aligned address. The third is a status-read frame that is held open until the device reports not-busy. When the sequence ends it gives a one-cycle completion pulse.

The serial bus runs in SPI mode 0. The clock idles low, outgoing data changes on falling edges, and incoming data is sampled on rising edges. Between any two frames, chip-select is held high for a programmable number of system clocks. Status polling is bounded by a limit on the number of status bytes. If the device is still busy when the limit is reached, the sequencer closes the frame, flags an error and returns to idle. A device ignores an erase aimed at a protected region without reporting it, so a clean completion means only that the sequence was issued.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, ready_o is 1, cs_no is 1, sck_o is 0, and done_o and err_o are 0.
- R2: An accepted request first sends a frame that contains only the byte 06h, and closes it before the erase frame opens.
- R3: The erase frame's first byte is 20h when size_blk_i=0. When size_blk_i=1 it is 52h if blk_op_alt_i=0 and D8h if blk_op_alt_i=1. blk_op_alt_i has no effect on sector erases.
- R4: The opcode is followed by exactly three address bytes, most significant first, in the same frame. For a sector, address bits 11..0 are sent as zero. For a block, bits 14..0 are sent as zero. The upper bits are copied from addr_i.
- R5: sck_o is 0 whenever cs_no is 1, and mosi_o changes only while sck_o is low. Bytes are sent MSB first.
- R6: Between the end of one frame and the start of the next, cs_no stays high for at least CS_GAP_CYC system clocks.
- R7: The third frame sends 05h and then 00h bytes in the same frame. Each returned byte is examined, and the frame ends after the first returned byte whose bit 0 (the last bit received) is 0.
- R8: If POLL_LIMIT returned status bytes all have bit 0 set, the frame is closed after the last of them, err_o is set and the sequencer returns to idle.
- R9: start_i is accepted only while ready_o is 1. A start_i pulse during a sequence has no effect on the bus traffic or on the number of sequences run.
- R10: done_o is a one-cycle pulse, asserted together with the return of ready_o after the closing chip-select gap. err_o is valid at done_o, holds until the next accepted start, and is cleared by that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when ready_o is 1 |
| addr_i | input | 24 | Byte address inside the region to erase |
| size_blk_i | input | 1 | 0: 4 KB sector, 1: 32 KB block |
| blk_op_alt_i | input | 1 | Block opcode select: 0 sends 52h, 1 sends D8h |
| ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Status poll limit was reached |
| sck_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The assertions assume that miso_i is driven to a known level during status frames, and that start_i is a clean synchronous level. They also assume that reset is held long enough for cs_no to settle high. The frame-gap property counts chip-select high time from a saturated value after reset, so a request made right after reset is not taken as a short gap. The bench's flash model drives miso_i only after a falling serial-clock edge, and it drives the busy flag only in the final bit of each status byte. All bench stimulus is applied at negative system-clock edges.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_SECT  = 8'h20;
  localparam logic [7:0] OPC_BLK_A = 8'h52;
  localparam logic [7:0] OPC_BLK_B = 8'hD8;
  localparam logic [7:0] OPC_DUMMY = 8'h00;

  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned SECT_LSB = 12;
  localparam int unsigned BLK_LSB  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP,
    ST_ERASE,
    ST_STAT,
    ST_POLL
  } seq_st_e;
endpackage

// File: rtl/fe_spi_byte.sv
module fe_spi_byte #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic       bit0_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          act_q, sck_q, done_q, smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        sh_q  <= tx_i;
        act_q <= 1'b1;
        div_q <= '0;
        bit_q <= '0;
        sck_q <= 1'b0;
      end else if (act_q) begin
        if (div_q == CW'(HALF_CYC - 1)) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            smp_q <= miso_i;       // rising edge: sample
          end else begin
            sck_q <= 1'b0;         // falling edge: advance
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
  assign done_o = done_q;
  assign bit0_o = smp_q;
endmodule

// File: rtl/fe_seq_ctrl.sv
module fe_seq_ctrl
  import flash_erase_pkg::*;
#(
  parameter int unsigned CS_GAP_CYC = 4,
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_blk_i,
  input  logic              blk_op_alt_i,
  input  logic              sh_done_i,
  input  logic              sh_bit0_i,
  output logic              go_o,
  output logic [7:0]        tx_o,
  output logic              cs_no,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned GW = $clog2(CS_GAP_CYC + 1);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));

  seq_st_e           st_q, nxt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        op_q, tx_q, addr_byte;
  logic [1:0]        idx_q;
  logic [GW-1:0]     gap_q;
  logic [PW-1:0]     poll_q;
  logic              go_q, cs_n_q, done_q, err_q, err_pend_q;

  always_comb begin
    unique case (idx_q)
      2'd0:    addr_byte = addr_q[23:16];
      2'd1:    addr_byte = addr_q[15:8];
      default: addr_byte = addr_q[7:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      addr_q     <= '0;
      op_q       <= '0;
      tx_q       <= '0;
      idx_q      <= '0;
      gap_q      <= '0;
      poll_q     <= '0;
      go_q       <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_pend_q <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q <= addr_i & (size_blk_i ? BLK_MASK : SECT_MASK);
          op_q   <= !size_blk_i ? OPC_SECT : (blk_op_alt_i ? OPC_BLK_B : OPC_BLK_A);
          err_q  <= 1'b0;
          cs_n_q <= 1'b0;
          go_q   <= 1'b1;
          tx_q   <= OPC_WREN;
          st_q   <= ST_WREN;
        end
        ST_WREN: if (sh_done_i) begin
          cs_n_q <= 1'b1;
          gap_q  <= '0;
          nxt_q  <= ST_ERASE;
          st_q   <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == GW'(CS_GAP_CYC - 1)) begin
            if (nxt_q == ST_IDLE) begin
              done_q <= 1'b1;
              err_q  <= err_pend_q;
              st_q   <= ST_IDLE;
            end else begin
              cs_n_q <= 1'b0;
              go_q   <= 1'b1;
              idx_q  <= '0;
              tx_q   <= (nxt_q == ST_ERASE) ? op_q : OPC_RDSR;
              st_q   <= nxt_q;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_ERASE: if (sh_done_i) begin
          if (idx_q == 2'd3) begin
            cs_n_q <= 1'b1;   // rising CE# starts the erase
            gap_q  <= '0;
            nxt_q  <= ST_STAT;
            st_q   <= ST_GAP;
          end else begin
            go_q  <= 1'b1;
            tx_q  <= addr_byte;
            idx_q <= idx_q + 2'd1;
          end
        end
        ST_STAT: if (sh_done_i) begin
          go_q   <= 1'b1;
          tx_q   <= OPC_DUMMY;
          poll_q <= '0;
          st_q   <= ST_POLL;
        end
        ST_POLL: if (sh_done_i) begin
          if (!sh_bit0_i || poll_q == PW'(POLL_LIMIT - 1)) begin
            err_pend_q <= sh_bit0_i;
            cs_n_q     <= 1'b1;
            gap_q      <= '0;
            nxt_q      <= ST_IDLE;
            st_q       <= ST_GAP;
          end else begin
            go_q   <= 1'b1;
            tx_q   <= OPC_DUMMY;
            poll_q <= poll_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o    = go_q;
  assign tx_o    = tx_q;
  assign cs_no   = cs_n_q;
  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int unsigned SCK_HALF_CYC = 2,
  parameter int unsigned CS_GAP_CYC   = 4,
  parameter int unsigned POLL_LIMIT   = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_blk_i,
  input  logic              blk_op_alt_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic       go, sh_done, sh_bit0;
  logic [7:0] tx;

  fe_seq_ctrl #(
    .CS_GAP_CYC (CS_GAP_CYC),
    .POLL_LIMIT (POLL_LIMIT)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .size_blk_i   (size_blk_i),
    .blk_op_alt_i (blk_op_alt_i),
    .sh_done_i    (sh_done),
    .sh_bit0_i    (sh_bit0),
    .go_o         (go),
    .tx_o         (tx),
    .cs_no        (cs_no),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  fe_spi_byte #(
    .HALF_CYC (SCK_HALF_CYC)
  ) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .tx_i   (tx),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .done_o (sh_done),
    .bit0_o (sh_bit0)
  );
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int unsigned CS_GAP = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic done_o,
  input logic err_o,
  input logic sck_o,
  input logic cs_no,
  input logic mosi_o
);
  localparam int unsigned HW = $clog2(CS_GAP + 2);

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_q <= HW'(CS_GAP);
    else if (!cs_no)             hi_q <= '0;
    else if (hi_q < HW'(CS_GAP)) hi_q <= hi_q + 1'b1;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);  // R5
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));  // R5
  AST_CS_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_q >= HW'(CS_GAP)));  // R6
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);  // R1
  AST_START_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (!ready_o && !cs_no));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && $past(!ready_o)));  // R10
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);  // R8
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .CS_GAP (CS_GAP_CYC)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .sck_o   (sck_o),
  .cs_no   (cs_no),
  .mosi_o  (mosi_o)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
  localparam int unsigned HALF = 2;
  localparam int unsigned GAP  = 4;
  localparam int unsigned LIM  = 8;

  typedef struct packed {
    logic [23:0] addr;
    logic        blk;
    logic        alt;
    logic [7:0]  busy;
    logic [7:0]  op;
    logic [23:0] eaddr;
    logic [7:0]  polls;
    logic        err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h123456, 1'b0, 1'b0, 8'd2,  8'h20, 24'h123000, 8'd3, 1'b0},
    '{24'hABCDEF, 1'b1, 1'b0, 8'd0,  8'h52, 24'hAB8000, 8'd1, 1'b0},
    '{24'h7FFFFF, 1'b1, 1'b1, 8'd5,  8'hD8, 24'h7F8000, 8'd6, 1'b0},
    '{24'hFFFFFF, 1'b0, 1'b1, 8'd1,  8'h20, 24'hFFF000, 8'd2, 1'b0},
    '{24'h000FFF, 1'b0, 1'b0, 8'd20, 8'h20, 24'h000000, 8'd8, 1'b1},
    '{24'h3C7ABC, 1'b1, 1'b0, 8'd7,  8'h52, 24'h3C0000, 8'd8, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic size_blk_i = 1'b0, blk_op_alt_i = 1'b0, miso = 1'b0;
  logic ready_o, done_o, err_o, sck_o, cs_no, mosi_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  flash_erase_seq #(
    .SCK_HALF_CYC (HALF),
    .CS_GAP_CYC   (GAP),
    .POLL_LIMIT   (LIM)
  ) i_flash_erase_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .size_blk_i   (size_blk_i),
    .blk_op_alt_i (blk_op_alt_i),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .sck_o        (sck_o),
    .cs_no        (cs_no),
    .mosi_o       (mosi_o),
    .miso_i       (miso)
  );

  // flash model: captures frames, answers status polls
  logic [7:0] fbuf [32][4];
  int flen [32];
  int m_fidx = 0, m_bits = 0, m_bytes = 0, polls_left = 0, busy_cfg = 0;
  logic [7:0] m_sh = '0;
  logic p_cs = 1'b1, p_sck = 1'b0;

  always @(cs_no, sck_o) begin
    if (p_cs === 1'b1 && cs_no === 1'b0) begin
      m_bits = 0; m_bytes = 0;
    end else if (p_cs === 1'b0 && cs_no === 1'b1) begin
      if (m_fidx < 32) flen[m_fidx] = m_bytes;
      if (m_fidx < 32 && fbuf[m_fidx][0] != 8'h06 && fbuf[m_fidx][0] != 8'h05)
        polls_left = busy_cfg;
      m_fidx++;
    end
    if (p_sck === 1'b0 && sck_o === 1'b1 && cs_no === 1'b0) begin
      m_sh = {m_sh[6:0], mosi_o};
      m_bits++;
      if (m_bits == 8) begin
        if (m_fidx < 32 && m_bytes < 4) fbuf[m_fidx][m_bytes] = m_sh;
        if (m_fidx < 32 && m_bytes >= 1 && fbuf[m_fidx][0] == 8'h05 && polls_left > 0)
          polls_left--;
        m_bytes++;
        m_bits = 0;
      end
    end
    if (p_sck === 1'b1 && sck_o === 1'b0) begin
      miso = (cs_no === 1'b0 && m_fidx < 32 && m_bytes >= 1 && m_bits == 7 &&
              fbuf[m_fidx][0] == 8'h05) ? (polls_left > 0) : 1'b0;
    end
    p_cs = cs_no;
    p_sck = sck_o;
  end

  // bus-timing monitor
  int mode_viol = 0, hi_run = 0, min_gap = 1000;
  logic q_sck = 1'b0, q_mosi = 1'b0, q_cs = 1'b1, seen_frame = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sck_o && q_sck && mosi_o !== q_mosi) mode_viol++;
      if (cs_no && sck_o) mode_viol++;
      if (q_cs && !cs_no && seen_frame && hi_run < min_gap) min_gap = hi_run;
      if (!cs_no) seen_frame = 1'b1;
      hi_run = cs_no ? hi_run + 1 : 0;
    end
    q_sck = sck_o; q_mosi = mosi_o; q_cs = cs_no;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_start(input logic [23:0] a, input logic b, input logic s);
    @(negedge clk_i);
    addr_i = a; size_blk_i = b; blk_op_alt_i = s; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic got_err, output int ok);
    ok = 0; got_err = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk_i);
      if (done_o) begin
        got_err = err_o;
        chk(ready_o, "R10 ready at done", ready_o, 1);
        @(negedge clk_i);
        chk(!done_o, "R10 done width", done_o, 0);
        ok = 1;
        break;
      end
    end
    chk(ok == 1, "R10 done seen", ok, 1);
  endtask

  task automatic check_frames(input int base, input vec_t v);
    chk(m_fidx - base == 3, "R2 frame count", m_fidx - base, 3);
    chk(flen[base] == 1 && fbuf[base][0] == 8'h06, "R2 write-enable frame",
        {flen[base], fbuf[base][0]}, {32'd1, 8'h06});
    chk(flen[base+1] == 4, "R4 erase frame length", flen[base+1], 4);
    chk(fbuf[base+1][0] == v.op, "R3 erase opcode", fbuf[base+1][0], v.op);
    chk({fbuf[base+1][1], fbuf[base+1][2], fbuf[base+1][3]} == v.eaddr, "R4 address",
        {fbuf[base+1][1], fbuf[base+1][2], fbuf[base+1][3]}, v.eaddr);
    chk(fbuf[base+2][0] == 8'h05, "R7 status opcode", fbuf[base+2][0], 8'h05);
    chk(flen[base+2] - 1 == int'(v.polls), "R7 R8 poll bytes", flen[base+2] - 1, v.polls);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic e;
    int ok, base;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o && cs_no && !sck_o && !done_o && !err_o, "R1 reset outputs",
        {ready_o, cs_no, sck_o, done_o, err_o}, 5'b11000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(ready_o && cs_no && !sck_o, "R1 idle after release", {ready_o, cs_no, sck_o}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      busy_cfg = VECS[i].busy;
      base = m_fidx;
      pulse_start(VECS[i].addr, VECS[i].blk, VECS[i].alt);
      chk(!ready_o, "R9 request accepted", ready_o, 0);
      chk(!err_o, "R10 err cleared on start", err_o, 0);
      wait_done(e, ok);
      chk(e == VECS[i].err, "R8 error flag", e, VECS[i].err);
      check_frames(base, VECS[i]);
      if (VECS[i].err) begin
        repeat (20) @(negedge clk_i);
        chk(err_o && ready_o, "R10 err held in idle", {err_o, ready_o}, 2'b11);
      end
    end

    // R9: start during a sequence is ignored
    busy_cfg = 1;
    base = m_fidx;
    pulse_start(24'h054321, 1'b0, 1'b0);
    repeat (30) @(negedge clk_i);
    pulse_start(24'hFFFFFF, 1'b1, 1'b1);
    wait_done(e, ok);
    check_frames(base, '{24'h054321, 1'b0, 1'b0, 8'd1, 8'h20, 24'h054000, 8'd2, 1'b0});
    repeat (300) @(negedge clk_i);
    chk(m_fidx - base == 3 && ready_o, "R9 no extra sequence", m_fidx - base, 3);

    // R5, R6 bus timing across all sequences
    chk(mode_viol == 0, "R5 data stable while clock high", mode_viol, 0);
    chk(min_gap >= int'(GAP), "R6 chip-select high gap", min_gap, GAP);
    finish_run();
  end
endmodule